// File: doc/BRIEF.md
# Interrupt Vector Request and Service Tracker

This block keeps three 256-bit maps, one bit per interrupt vector. The request map holds vectors that have been raised and not yet taken. The in-service map holds vectors that the processor has accepted and not yet retired. The enable map decides which vectors may be raised at all. A raise strobe sets a request bit, but only when the matching enable bit is 1. An acknowledge strobe moves a chosen vector from the request map to the in-service map. An end-of-interrupt strobe retires the highest-numbered vector in service, so no vector number is needed with it.

The pending output is high while any request bit is set. It comes with the number of the highest requested vector, which is the one to take next. All the maps can be read as 32-bit words through a register port. The enable map can also be written through that port. The port is addressed by register index, where the index is the byte offset divided by 16. A trigger-mode window is part of the map and always reads zero.

Top module: `vec_track`

## Requirements
- R1: Vector v is bit v%32 of word v/32 of each map. Word k of a map is read at index base+k, and word 0 holds vectors 0 to 31.
- R2: A raise sets the request bit of raise_vec only when that vector's enable bit is 1 in the cycle of the raise. Otherwise the raise is dropped and the request map is unchanged.
- R3: After reset the request and in-service maps are all zero, the enable map is all ones and pend is 0.
- R4: pend is 1 exactly when some request bit is set. While pend is 1, pend_vec is the highest-numbered set request bit.
- R5: An acknowledge of ack_vec sets that vector's in-service bit and clears its request bit on the next clock edge.
- R6: An end-of-interrupt strobe clears the highest-numbered set in-service bit. With no in-service bit set it changes nothing.
- R7: Read indices are 0x10-0x17 for in-service, 0x18-0x1F for trigger mode (always zero), 0x20-0x27 for request and 0x48-0x4F for enable (byte offsets 0x100, 0x180, 0x200 and 0x480). Any other index reads zero.
- R8: A write at an enable index replaces that enable word. Writes at any other index have no effect. Changing the enable map does not alter request bits that are already set.
- R9: When a raise and an acknowledge name the same vector in the same cycle, the acknowledge wins: the in-service bit is set and the request bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise strobe for raise_vec |
| raise_vec | input | 8 | Vector to raise |
| ack_vld | input | 1 | Acknowledge strobe for ack_vec |
| ack_vec | input | 8 | Vector being accepted |
| eoi | input | 1 | End-of-interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index for the write (byte offset / 16) |
| wr_data | input | 32 | Write data |
| rd_idx | input | 8 | Register index for the read (byte offset / 16) |
| rd_data | output | 32 | Read data, combinational from rd_idx |
| pend | output | 1 | Some request bit is set |
| pend_vec | output | 8 | Highest requested vector, valid while pend is 1 |

## Verification
The assertions take for granted that each strobe is sampled once per cycle and that the vector inputs are stable for the whole cycle in which their strobe is high. They also assume an end-of-interrupt is not given in the same cycle as an acknowledge of the vector it would retire; the retire check excludes that case. The stimulus drives every strobe for exactly one cycle, changing it on the falling edge. It uses the combined raise-and-acknowledge case only where R9 calls for it, and it reads the maps back through the register port between operations.

// File: rtl/vt_pkg.sv
package vt_pkg;

  // Register windows of the read/write port (index = byte offset / 16)
  typedef enum logic [2:0] {
    RG_NONE,
    RG_ISR,
    RG_TRIG,
    RG_IRR,
    RG_EN
  } vt_region_e;

  localparam int unsigned VT_IDX_W = 8;

  // Decode a register index into a window; words past nwords are unmapped.
  function automatic vt_region_e vt_decode(input logic [VT_IDX_W-1:0] idx,
                                           input int unsigned nwords);
    vt_region_e r;
    case (idx[7:3])
      5'd2:    r = RG_ISR;
      5'd3:    r = RG_TRIG;
      5'd4:    r = RG_IRR;
      5'd9:    r = RG_EN;
      default: r = RG_NONE;
    endcase
    if (int'(idx[2:0]) >= int'(nwords)) r = RG_NONE;
    return r;
  endfunction

endpackage

// File: rtl/vt_prio_enc.sv
// Highest-set-bit finder, split into segments so each level stays shallow.
module vt_prio_enc #(
  parameter int unsigned W   = 256,
  parameter int unsigned SEG = 32
) (
  input  logic [W-1:0]         vec_i,
  output logic                 any_o,
  output logic [$clog2(W)-1:0] idx_o
);
  localparam int unsigned NSEG  = W / SEG;
  localparam int unsigned SEG_W = $clog2(SEG);
  localparam int unsigned IDX_W = $clog2(W);

  logic [NSEG-1:0]       seg_any;
  logic [NSEG*SEG_W-1:0] seg_idx;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = 0; b < SEG; b++) begin
        if (vec_i[s*SEG+b]) loc = SEG_W'(b);
      end
    end
    assign seg_any[s]                   = |vec_i[s*SEG +: SEG];
    assign seg_idx[s*SEG_W +: SEG_W]    = loc;
  end

  always_comb begin
    idx_o = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_any[s]) idx_o = IDX_W'(s*SEG) + IDX_W'(seg_idx[s*SEG_W +: SEG_W]);
    end
  end

  assign any_o = |seg_any;

endmodule

// File: rtl/vt_bitmaps.sv
// Request, in-service and enable maps with their next-state rules.
module vt_bitmaps #(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     raise_vld,
  input  logic [$clog2(NVEC)-1:0]  raise_vec,
  input  logic                     ack_vld,
  input  logic [$clog2(NVEC)-1:0]  ack_vec,
  input  logic                     eoi_vld,
  input  logic                     isr_any,
  input  logic [$clog2(NVEC)-1:0]  isr_top,
  input  logic                     en_wr_vld,
  input  logic [((NVEC/WORD_W)>1 ? $clog2(NVEC/WORD_W) : 1)-1:0] en_wr_word,
  input  logic [WORD_W-1:0]        en_wr_data,
  output logic [NVEC-1:0]          irr_q,
  output logic [NVEC-1:0]          isr_q,
  output logic [NVEC-1:0]          en_q
);
  localparam int unsigned VEC_W  = $clog2(NVEC);
  localparam int unsigned NWORDS = NVEC / WORD_W;
  localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  function automatic logic [NVEC-1:0] vec_bit(input logic [VEC_W-1:0] v);
    return {{(NVEC-1){1'b0}}, 1'b1} << v;
  endfunction

  // Named internal events
  logic [NVEC-1:0]   raise_mask, ack_mask, eoi_mask;
  logic [NVEC-1:0]   irr_d, isr_d;
  logic [NWORDS-1:0] en_we;
  logic              eoi_hit;

  assign eoi_hit    = eoi_vld && isr_any;
  assign raise_mask = raise_vld ? (vec_bit(raise_vec) & en_q) : '0;
  assign ack_mask   = ack_vld   ? vec_bit(ack_vec) : '0;
  assign eoi_mask   = eoi_hit   ? vec_bit(isr_top) : '0;

  // Acknowledge is applied last, so it wins over a raise of the same vector.
  assign irr_d = (irr_q | raise_mask) & ~ack_mask;
  assign isr_d = (isr_q & ~eoi_mask) | ack_mask;

  for (genvar w = 0; w < NWORDS; w++) begin : g_we
    assign en_we[w] = en_wr_vld && (en_wr_word == WIDX_W'(w));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      en_q  <= '1;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      for (int w = 0; w < NWORDS; w++) begin
        if (en_we[w]) en_q[w*WORD_W +: WORD_W] <= en_wr_data;
      end
    end
  end

  assert_raise_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && en_q[raise_vec] && !(ack_vld && ack_vec == raise_vec))
      |=> irr_q[$past(raise_vec)]);

  assert_raise_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && !en_q[raise_vec] && !irr_q[raise_vec])
      |=> !irr_q[$past(raise_vec)]);

  assert_ack_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> (isr_q[$past(ack_vec)] && !irr_q[$past(ack_vec)]));

  assert_ack_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && ack_vld && raise_vec == ack_vec) |=> !irr_q[$past(ack_vec)]);

  assert_eoi_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && isr_any && !(ack_vld && ack_vec == isr_top))
      |=> !isr_q[$past(isr_top)]);

  assert_eoi_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && !isr_any && !ack_vld) |=> $stable(isr_q));

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_vld |=> $stable(en_q));

endmodule

// File: rtl/vt_regport.sv
// Word view of the maps: combinational read mux and enable write decode.
module vt_regport
  import vt_pkg::*;
#(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned WORD_W = 32
) (
  input  logic [VT_IDX_W-1:0] rd_idx,
  output logic [WORD_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [VT_IDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [NVEC-1:0]     irr_q,
  input  logic [NVEC-1:0]     isr_q,
  input  logic [NVEC-1:0]     en_q,
  output logic                en_wr_vld,
  output logic [((NVEC/WORD_W)>1 ? $clog2(NVEC/WORD_W) : 1)-1:0] en_wr_word,
  output logic [WORD_W-1:0]   en_wr_data
);
  localparam int unsigned NWORDS = NVEC / WORD_W;
  localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  vt_region_e        rd_reg, wr_reg;
  logic [WIDX_W-1:0] rd_word;
  int unsigned       rd_base;

  assign rd_reg  = vt_decode(rd_idx, NWORDS);
  assign wr_reg  = vt_decode(wr_idx, NWORDS);
  assign rd_word = rd_idx[WIDX_W-1:0];
  assign rd_base = int'(rd_word) * WORD_W;

  always_comb begin
    case (rd_reg)
      RG_ISR:  rd_data = isr_q[rd_base +: WORD_W];
      RG_IRR:  rd_data = irr_q[rd_base +: WORD_W];
      RG_EN:   rd_data = en_q[rd_base +: WORD_W];
      default: rd_data = '0;
    endcase
  end

  assign en_wr_vld  = wr_en && (wr_reg == RG_EN);
  assign en_wr_word = wr_idx[WIDX_W-1:0];
  assign en_wr_data = wr_data;

endmodule

// File: rtl/vec_track.sv
module vec_track
  import vt_pkg::*;
#(
  parameter int unsigned NVEC   = 256,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEG    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    raise_vld,
  input  logic [$clog2(NVEC)-1:0] raise_vec,
  input  logic                    ack_vld,
  input  logic [$clog2(NVEC)-1:0] ack_vec,
  input  logic                    eoi,
  input  logic                    wr_en,
  input  logic [VT_IDX_W-1:0]     wr_idx,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [VT_IDX_W-1:0]     rd_idx,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    pend,
  output logic [$clog2(NVEC)-1:0] pend_vec
);
  localparam int unsigned VEC_W  = $clog2(NVEC);
  localparam int unsigned NWORDS = NVEC / WORD_W;
  localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [NVEC-1:0]   irr_q, isr_q, en_q;
  logic              isr_any;
  logic [VEC_W-1:0]  isr_top;
  logic              en_wr_vld;
  logic [WIDX_W-1:0] en_wr_word;
  logic [WORD_W-1:0] en_wr_data;

  vt_prio_enc #(.W(NVEC), .SEG(SEG)) u_irr_enc (
    .vec_i (irr_q),
    .any_o (pend),
    .idx_o (pend_vec)
  );

  vt_prio_enc #(.W(NVEC), .SEG(SEG)) u_isr_enc (
    .vec_i (isr_q),
    .any_o (isr_any),
    .idx_o (isr_top)
  );

  vt_bitmaps #(.NVEC(NVEC), .WORD_W(WORD_W)) u_maps (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_vld  (raise_vld),
    .raise_vec  (raise_vec),
    .ack_vld    (ack_vld),
    .ack_vec    (ack_vec),
    .eoi_vld    (eoi),
    .isr_any    (isr_any),
    .isr_top    (isr_top),
    .en_wr_vld  (en_wr_vld),
    .en_wr_word (en_wr_word),
    .en_wr_data (en_wr_data),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .en_q       (en_q)
  );

  vt_regport #(.NVEC(NVEC), .WORD_W(WORD_W)) u_port (
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .en_q       (en_q),
    .en_wr_vld  (en_wr_vld),
    .en_wr_word (en_wr_word),
    .en_wr_data (en_wr_data)
  );

  assert_pend_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (irr_q[pend_vec] && ((irr_q >> pend_vec) == NVEC'(1))));

  assert_pend_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (irr_q == '0));

  assert_isr_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    isr_any |-> isr_q[isr_top]);

endmodule

// File: tb/sim_vec_track.sv
module sim_vec_track;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_vld, ack_vld, eoi, wr_en;
  logic [7:0]  raise_vec, ack_vec, wr_idx, rd_idx;
  logic [31:0] wr_data, rd_data;
  logic        pend;
  logic [7:0]  pend_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vec_track u0 (
    .clk (clk), .rst_n (rst_n),
    .raise_vld (raise_vld), .raise_vec (raise_vec),
    .ack_vld (ack_vld), .ack_vec (ack_vec),
    .eoi (eoi),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .rd_idx (rd_idx), .rd_data (rd_data),
    .pend (pend), .pend_vec (pend_vec)
  );

  // op: 0 raise, 1 acknowledge, 2 end-of-interrupt
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] vec;
    logic       ep;
    logic [7:0] ev;
  } step_t;

  localparam int NSTEP = 12;
  localparam step_t TBL [NSTEP] = '{
    '{2'd0, 8'h21, 1'b1, 8'h21},
    '{2'd0, 8'hF0, 1'b1, 8'hF0},
    '{2'd0, 8'h05, 1'b1, 8'hF0},
    '{2'd1, 8'hF0, 1'b1, 8'h21},
    '{2'd1, 8'h21, 1'b1, 8'h05},
    '{2'd2, 8'h00, 1'b1, 8'h05},
    '{2'd0, 8'hFF, 1'b1, 8'hFF},
    '{2'd1, 8'hFF, 1'b1, 8'h05},
    '{2'd2, 8'h00, 1'b1, 8'h05},
    '{2'd1, 8'h05, 1'b0, 8'h00},
    '{2'd2, 8'h00, 1'b0, 8'h00},
    '{2'd0, 8'h00, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [7:0] rvec,
                       input logic av, input logic [7:0] avec, input logic e);
    @(negedge clk);
    raise_vld = rv; raise_vec = rvec; ack_vld = av; ack_vec = avec; eoi = e;
    @(negedge clk);
    raise_vld = 1'b0; ack_vld = 1'b0; eoi = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    rd_idx = idx;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; raise_vld = 1'b0; ack_vld = 1'b0; eoi = 1'b0; wr_en = 1'b0;
    raise_vec = '0; ack_vec = '0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R7: reset contents of every window
    chk("R3 pend", {31'd0, pend}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      rd(8'h10 + 8'(w), v); chk("R3 isr word", v, 32'h0);
      rd(8'h18 + 8'(w), v); chk("R7 trig word", v, 32'h0);
      rd(8'h20 + 8'(w), v); chk("R3 irr word", v, 32'h0);
      rd(8'h48 + 8'(w), v); chk("R3 en word", v, 32'hFFFF_FFFF);
    end

    // Table walk: R2 raise, R5 ack, R6 eoi, R4 pending vector
    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i].op == 2'd0, TBL[i].vec, TBL[i].op == 2'd1, TBL[i].vec, TBL[i].op == 2'd2);
      chk("R4 pend", {31'd0, pend}, {31'd0, TBL[i].ep});
      if (TBL[i].ep) chk("R4 pend_vec", {24'd0, pend_vec}, {24'd0, TBL[i].ev});
    end

    // R1 / R7: bit placement and windows (ISR holds 0x05, IRR holds 0x00)
    rd(8'h10, v); chk("R1 isr word0", v, 32'h0000_0020);
    rd(8'h20, v); chk("R1 irr word0", v, 32'h0000_0001);
    rd(8'h18, v); chk("R7 trig word0", v, 32'h0);
    rd(8'h30, v); chk("R7 unmapped", v, 32'h0);
    rd(8'h4F, v); chk("R7 en word7", v, 32'hFFFF_FFFF);

    // R8: writes outside the enable window are ignored
    wr(8'h20, 32'hFFFF_0000);
    rd(8'h20, v); chk("R8 irr write ignored", v, 32'h0000_0001);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R8 isr write ignored", v, 32'h0000_0020);

    // R2: masked vector 255 is dropped, enabled 254 is taken
    wr(8'h4F, 32'h7FFF_FFFF);
    rd(8'h4F, v); chk("R8 en readback", v, 32'h7FFF_FFFF);
    drive(1'b1, 8'hFF, 1'b0, 8'h00, 1'b0);
    rd(8'h27, v); chk("R2 masked raise", v, 32'h0);
    chk("R2 pend_vec after masked", {24'd0, pend_vec}, 32'h0);
    drive(1'b1, 8'hFE, 1'b0, 8'h00, 1'b0);
    rd(8'h27, v); chk("R2 enabled raise", v, 32'h4000_0000);
    chk("R4 pend_vec 254", {24'd0, pend_vec}, 32'hFE);

    // R8: clearing enables leaves pending requests alone
    wr(8'h4F, 32'h0);
    rd(8'h27, v); chk("R8 irr kept", v, 32'h4000_0000);
    chk("R8 pend_vec kept", {24'd0, pend_vec}, 32'hFE);

    // R9: raise and acknowledge of 0x80 in one cycle
    drive(1'b1, 8'h80, 1'b1, 8'h80, 1'b0);
    rd(8'h24, v); chk("R9 irr clear", v, 32'h0);
    rd(8'h14, v); chk("R9 isr set", v, 32'h0000_0001);

    // R6: retire highest first, then empty case
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    rd(8'h14, v); chk("R6 eoi 0x80", v, 32'h0);
    rd(8'h10, v); chk("R6 0x05 kept", v, 32'h0000_0020);
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    rd(8'h10, v); chk("R6 eoi 0x05", v, 32'h0);
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    rd(8'h10, v); chk("R6 empty eoi isr0", v, 32'h0);
    rd(8'h27, v); chk("R6 empty eoi irr", v, 32'h4000_0000);

    // R5 / R4: acknowledge the remaining requests
    drive(1'b0, 8'h00, 1'b1, 8'hFE, 1'b0);
    rd(8'h17, v); chk("R5 isr word7", v, 32'h4000_0000);
    rd(8'h27, v); chk("R5 irr word7", v, 32'h0);
    drive(1'b0, 8'h00, 1'b1, 8'h00, 1'b0);
    chk("R4 pend low", {31'd0, pend}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule